// File: doc/BRIEF.md
# Keyed Configuration Port Register Controller

This block puts a bank of configuration registers for several on-board logical devices behind two byte-wide host addresses. One address is the index port and the next is the data port. Configuration is normally sealed. Writing the open key to the index port unseals it, and writing the close key to the same port seals it again. While the block is open, the host writes a register index to the index port and then reads or writes that register through the data port.

A logical-device selector register chooses which device bank the per-device indices reach. Each implemented device has its own independent copy of these registers:

- a 16-bit I/O base, split into a high byte and a low byte;
- a primary and a secondary interrupt number;
- a DMA channel;
- two mode bytes;
- an activate bit.

Each bank drives the active flag, base, interrupt and DMA outputs of its device directly, from the registers themselves. The host bus uses single-cycle write and read strobes. Read data is registered.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the block is sealed, the logical-device selector and the index are 0, every bank register is 0 (so all `dev_active` bits, bases, interrupt and DMA outputs are 0), and `bus_rdata` is 0x00.
- R2: While sealed, a write of 0x55 to the index port (`bus_sel`=0) unseals the block. Every other index-port write and every data-port write while sealed has no effect on any register or output.
- R3: While sealed, a read of either port returns 0xFF.
- R4: While unsealed, a write of 0xAA to the index port seals the block and leaves the index unchanged. Data writes after that have no effect.
- R5: While unsealed, any other index-port write loads the index, and a read of the index port returns the current index.
- R6: Index 0x07 holds the logical-device selector, which is read/write and 8 bits wide. Implemented devices are 0, 3, 4, 5 and 7, and they map to export slots 0, 1, 2, 3 and 4 in that order.
- R7: Index 0x20 reads as the chip identifier 0x40. Writes to it are ignored.
- R8: In the selected bank, index 0x60 is the base high byte and index 0x61 the low byte. The slot's `dev_base` equals {high, low}.
- R9: In the selected bank, index 0x70 is the primary interrupt and drives `dev_irq`. Index 0x74 is the DMA channel and drives `dev_dma`. Index 0x72 is a secondary interrupt that is read/write only. All three are full bytes.
- R10: In the selected bank, index 0x30 bit 0 is the activate bit that drives `dev_active`. Bits 7:1 are ignored on write and read back as 0.
- R11: In the selected bank, indices 0xF0 and 0xF1 are read/write mode bytes.
- R12: Indices that are not implemented read 0x00 and ignore writes. When the selector names a device with no bank, all per-device indices read 0x00 and writes change nothing.
- R13: A data write changes only the selected bank. The other banks keep their values.
- R14: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dev_active | output | NUM_DEV | Activate bit per slot |
| dev_base | output | NUM_DEV*16 | I/O base per slot, slot k at bits [16k+15:16k] |
| dev_irq | output | NUM_DEV*8 | Primary interrupt per slot |
| dev_dma | output | NUM_DEV*8 | DMA channel per slot |

## Verification
A wrong lock state shows up at the very next read, because a sealed port returns 0xFF where an open one returns a register value. It also shows up in the next exported field after a write that should have been dropped. A stuck or mis-decoded device selector shows up as a write that lands in the wrong slot's `dev_base`, `dev_irq` or `dev_dma`, one cycle after the data strobe. It can also surface later as a readback that disagrees with the bench model. The random traffic checks the exported fields every few dozen operations, so a corrupted bank register is found well within that window, even if the host never reads that register.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam logic [7:0] KEY_OPEN   = 8'h55;
  localparam logic [7:0] KEY_SHUT   = 8'hAA;
  localparam logic [7:0] IX_LDN     = 8'h07;
  localparam logic [7:0] IX_CHIPID  = 8'h20;
  localparam logic [7:0] IX_ACT     = 8'h30;
  localparam logic [7:0] IX_BASE_HI = 8'h60;
  localparam logic [7:0] IX_BASE_LO = 8'h61;
  localparam logic [7:0] IX_IRQ_A   = 8'h70;
  localparam logic [7:0] IX_IRQ_B   = 8'h72;
  localparam logic [7:0] IX_DMA     = 8'h74;
  localparam logic [7:0] IX_MODE_A  = 8'hF0;
  localparam logic [7:0] IX_MODE_B  = 8'hF1;

  typedef enum logic {ST_SHUT = 1'b0, ST_OPEN = 1'b1} lock_state_t;

  typedef struct packed {
    logic [7:0] base_hi;
    logic [7:0] base_lo;
    logic [7:0] irq_a;
    logic [7:0] irq_b;
    logic [7:0] dma;
    logic [7:0] mode_a;
    logic [7:0] mode_b;
    logic       act;
  } bank_regs_t;
endpackage

// File: rtl/cfgport_lock.sv
module cfgport_lock
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open
);
  lock_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SHUT;
    end else if (idx_wr) begin
      if (state_q == ST_SHUT && wdata == KEY_OPEN)
        state_q <= ST_OPEN;
      else if (state_q == ST_OPEN && wdata == KEY_SHUT)
        state_q <= ST_SHUT;
    end
  end

  assign cfg_open = (state_q == ST_OPEN);

  // R2: the open key unseals the block
  p_key_open_r2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && idx_wr && wdata == KEY_OPEN) |=> cfg_open);
  // R4: the close key seals the block
  p_key_shut_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && idx_wr && wdata == KEY_SHUT) |=> !cfg_open);
  // R2: nothing but a key write moves the lock
  p_lock_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!idx_wr || (wdata != KEY_OPEN && wdata != KEY_SHUT)) |=> $stable(cfg_open));
endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
  import cfgport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          wr_en,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output bank_regs_t    regs
);
  bank_regs_t regs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else if (wr_en) begin
      case (idx)
        IX_BASE_HI: regs_q.base_hi <= wdata;
        IX_BASE_LO: regs_q.base_lo <= wdata;
        IX_IRQ_A:   regs_q.irq_a   <= wdata;
        IX_IRQ_B:   regs_q.irq_b   <= wdata;
        IX_DMA:     regs_q.dma     <= wdata;
        IX_MODE_A:  regs_q.mode_a  <= wdata;
        IX_MODE_B:  regs_q.mode_b  <= wdata;
        IX_ACT:     regs_q.act     <= wdata[0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit) begin
      case (idx)
        IX_BASE_HI: rd_data = regs_q.base_hi;
        IX_BASE_LO: rd_data = regs_q.base_lo;
        IX_IRQ_A:   rd_data = regs_q.irq_a;
        IX_IRQ_B:   rd_data = regs_q.irq_b;
        IX_DMA:     rd_data = regs_q.dma;
        IX_MODE_A:  rd_data = regs_q.mode_a;
        IX_MODE_B:  rd_data = regs_q.mode_b;
        IX_ACT:     rd_data = {{(DW-1){1'b0}}, regs_q.act};
        default:    rd_data = '0;
      endcase
    end
  end

  assign regs = regs_q;

  // R10: only bit 0 of the activate write is kept
  p_act_bit0_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IX_ACT) |=> regs_q.act == $past(wdata[0]));
  // R8: the low base byte takes the written value
  p_base_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IX_BASE_LO) |=> regs_q.base_lo == $past(wdata));
  // R13: a bank that is not written keeps all of its registers
  p_bank_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int                   NUM_DEV  = 5,
  parameter logic [NUM_DEV*8-1:0] DEV_LIST = 40'h07_05_04_03_00,
  parameter logic [7:0]           CHIP_ID  = 8'h40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic                    bus_sel,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic [NUM_DEV-1:0]      dev_active,
  output logic [NUM_DEV*16-1:0]   dev_base,
  output logic [NUM_DEV*8-1:0]    dev_irq,
  output logic [NUM_DEV*8-1:0]    dev_dma
);
  localparam int DW = 8;

  logic          cfg_open;
  logic [DW-1:0] idx_q;
  logic [DW-1:0] ldn_q;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] bank_rd_or;
  logic [DW-1:0] bank_rd [NUM_DEV];
  logic [NUM_DEV-1:0] hit;
  logic          idx_wr;
  logic          dat_wr;

  assign idx_wr = bus_wr && !bus_sel;
  assign dat_wr = bus_wr && bus_sel && cfg_open;

  cfgport_lock u_lock (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .wdata    (bus_wdata),
    .cfg_open (cfg_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (idx_wr && cfg_open && bus_wdata != KEY_SHUT) begin
      idx_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q <= '0;
    end else if (dat_wr && idx_q == IX_LDN) begin
      ldn_q <= bus_wdata;
    end
  end

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_bank
    bank_regs_t regs;
    assign hit[k] = (ldn_q == DEV_LIST[k*8 +: 8]);
    cfgport_bank #(.DW(DW)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[k]),
      .wr_en   (dat_wr && hit[k]),
      .idx     (idx_q),
      .wdata   (bus_wdata),
      .rd_data (bank_rd[k]),
      .regs    (regs)
    );
    assign dev_active[k]         = regs.act;
    assign dev_base[k*16 +: 16]  = {regs.base_hi, regs.base_lo};
    assign dev_irq[k*8 +: 8]     = regs.irq_a;
    assign dev_dma[k*8 +: 8]     = regs.dma;
  end

  always_comb begin
    bank_rd_or = '0;
    for (int k = 0; k < NUM_DEV; k++) bank_rd_or = bank_rd_or | bank_rd[k];
  end

  always_comb begin
    if (!cfg_open)     rd_mux = 8'hFF;
    else if (!bus_sel) rd_mux = idx_q;
    else begin
      case (idx_q)
        IX_LDN:    rd_mux = ldn_q;
        IX_CHIPID: rd_mux = CHIP_ID;
        default:   rd_mux = bank_rd_or;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R3: sealed reads return all ones
  p_shut_read_ff_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && bus_rd) |=> bus_rdata == 8'hFF);
  // R7: the identifier index reads the chip identifier
  p_chipid_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && bus_rd && bus_sel && idx_q == IX_CHIPID) |=> bus_rdata == CHIP_ID);
  // R6: a selector write lands in the selector
  p_ldn_write_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && bus_wr && bus_sel && idx_q == IX_LDN) |=> ldn_q == $past(bus_wdata));
  // R2: sealed writes leave the exported fields alone
  p_shut_outputs_r2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && bus_wr) |=> ($stable(dev_active) && $stable(dev_base)
                               && $stable(dev_irq) && $stable(dev_dma)));
  // R5: an open index-port read returns the index
  p_idx_read_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && bus_rd && !bus_sel) |=> bus_rdata == $past(idx_q));
  // R14: read data holds between read strobes
  p_rdata_hold_r14: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_cfgport_ctrl.sv
module tb_cfgport_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [ND-1:0] dev_active;
  logic [ND*16-1:0] dev_base;
  logic [ND*8-1:0] dev_irq, dev_dma;

  int total = 0, bad = 0;
  bit done = 0;

  // model
  bit m_open;
  logic [7:0] m_idx, m_ldn;
  logic [7:0] m_reg [ND][8]; // 0 hi,1 lo,2 irqa,3 irqb,4 dma,5 ma,6 mb,7 act

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_ctrl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_active(dev_active),
    .dev_base(dev_base), .dev_irq(dev_irq), .dev_dma(dev_dma)
  );

  function automatic int slot_of(logic [7:0] l);
    case (l)
      8'h00: return 0;
      8'h03: return 1;
      8'h04: return 2;
      8'h05: return 3;
      8'h07: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic int field_of(logic [7:0] i);
    case (i)
      8'h60: return 0;
      8'h61: return 1;
      8'h70: return 2;
      8'h72: return 3;
      8'h74: return 4;
      8'hF0: return 5;
      8'hF1: return 6;
      8'h30: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(bit sel);
    int s, f;
    if (!m_open) return 8'hFF;
    if (!sel) return m_idx;
    if (m_idx == 8'h07) return m_ldn;
    if (m_idx == 8'h20) return 8'h40;
    s = slot_of(m_ldn);
    f = field_of(m_idx);
    if (s < 0 || f < 0) return 8'h00;
    return m_reg[s][f];
  endfunction

  function automatic string tag_of(bit sel);
    if (!m_open) return "R3";
    if (!sel) return "R5";
    case (m_idx)
      8'h07: return "R6";
      8'h20: return "R7";
      8'h60, 8'h61: return "R8";
      8'h70, 8'h72, 8'h74: return "R9";
      8'h30: return "R10";
      8'hF0, 8'hF1: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mdl_reset();
    m_open = 0; m_idx = 0; m_ldn = 0;
    for (int k = 0; k < ND; k++) for (int f = 0; f < 8; f++) m_reg[k][f] = 8'h00;
  endtask

  task automatic bus_write(bit sel, logic [7:0] v);
    int s, f;
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
    if (!sel) begin
      if (!m_open) begin
        if (v == 8'h55) m_open = 1;
      end else if (v == 8'hAA) m_open = 0;
      else m_idx = v;
    end else if (m_open) begin
      if (m_idx == 8'h07) m_ldn = v;
      else begin
        s = slot_of(m_ldn);
        f = field_of(m_idx);
        if (s >= 0 && f >= 0) m_reg[s][f] = (f == 7) ? {7'b0, v[0]} : v;
      end
    end
  endtask

  task automatic bus_read(bit sel, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = sel;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(bit sel, string tag);
    logic [7:0] v, e;
    e = exp_rd(sel);
    bus_read(sel, v);
    chk(tag, v, e);
  endtask

  task automatic chk_exports(string tag);
    for (int k = 0; k < ND; k++) begin
      chk(tag, dev_active[k], m_reg[k][7][0]);
      chk(tag, dev_base[k*16 +: 16], {m_reg[k][0], m_reg[k][1]});
      chk(tag, dev_irq[k*8 +: 8], m_reg[k][2]);
      chk(tag, dev_dma[k*8 +: 8], m_reg[k][4]);
    end
  endtask

  function automatic logic [7:0] pick_idx();
    case ($urandom_range(0, 11))
      0: return 8'h07;  1: return 8'h20;  2: return 8'h30;  3: return 8'h60;
      4: return 8'h61;  5: return 8'h70;  6: return 8'h72;  7: return 8'h74;
      8: return 8'hF0;  9: return 8'hF1;  10: return 8'h07;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  function automatic logic [7:0] pick_ldn();
    case ($urandom_range(0, 8))
      0: return 8'h00; 1: return 8'h03; 2: return 8'h04; 3: return 8'h05;
      4: return 8'h07; 5: return 8'h01; 6: return 8'h02; 7: return 8'h06;
      default: return 8'h09;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, hold;
    void'($urandom(32'd4242));
    mdl_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", bus_rdata, 8'h00);
    chk_exports("R1");

    // R2/R3 sealed behaviour
    bus_write(1, 8'h33);
    bus_write(0, 8'h07);
    bus_write(1, 8'h05);
    bus_write(0, 8'hAA);
    rd_chk(1, "R3 data port sealed");
    rd_chk(0, "R3 index port sealed");
    chk_exports("R2 sealed writes");

    // R2 unlock; index stays 0 -> unimplemented
    bus_write(0, 8'h55);
    rd_chk(0, "R2 open index=0");
    rd_chk(1, "R12 index 0");

    // R7
    bus_write(0, 8'h20);
    rd_chk(1, "R7 chip id");
    bus_write(1, 8'h12);
    rd_chk(1, "R7 write ignored");

    // R6 / R5
    bus_write(0, 8'h07);
    rd_chk(0, "R5 index readback");
    rd_chk(1, "R6 ldn reset 0");
    bus_write(1, 8'h04);
    rd_chk(1, "R6 ldn=4");

    // R8 R9 R10 R13 on slot 2 (device 4)
    bus_write(0, 8'h60); bus_write(1, 8'h03);
    bus_write(0, 8'h61); bus_write(1, 8'hF8);
    bus_write(0, 8'h70); bus_write(1, 8'h04);
    bus_write(0, 8'h74); bus_write(1, 8'h02);
    bus_write(0, 8'h30); bus_write(1, 8'h01);
    chk("R8 base slot2", dev_base[2*16 +: 16], 16'h03F8);
    chk("R9 irq slot2", dev_irq[2*8 +: 8], 8'h04);
    chk("R10 active slot2", dev_active, 5'b00100);
    chk_exports("R13 other slots untouched");
    bus_write(1, 8'hFE);
    chk("R10 bit0 only", dev_active[2], 1'b0);
    rd_chk(1, "R10 readback");

    // R11
    bus_write(0, 8'hF1); bus_write(1, 8'h5A);
    rd_chk(1, "R11 mode byte");

    // R12 selector without bank
    bus_write(0, 8'h07); bus_write(1, 8'h02);
    bus_write(0, 8'h60); bus_write(1, 8'h99);
    rd_chk(1, "R12 no bank read");
    chk_exports("R12 no bank write");
    bus_write(0, 8'h99);
    rd_chk(1, "R12 unimplemented index");

    // R14 hold
    bus_write(0, 8'h20);
    bus_read(1, hold);
    repeat (4) @(negedge clk);
    chk("R14 hold", bus_rdata, hold);
    bus_write(1, 8'h77);
    chk("R14 hold over write", bus_rdata, hold);

    // R4 close
    bus_write(0, 8'hAA);
    bus_write(1, 8'h11);
    rd_chk(1, "R4 sealed after close");
    bus_write(0, 8'h55);
    rd_chk(0, "R4 index kept");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 35) begin
        if (!m_open) v = ($urandom_range(0, 1) == 0) ? 8'h55 : 8'($urandom_range(0, 255));
        else v = ($urandom_range(0, 29) == 0) ? 8'hAA : pick_idx();
        bus_write(0, v);
      end else if (r < 70) begin
        v = (m_idx == 8'h07) ? pick_ldn() : 8'($urandom_range(0, 255));
        bus_write(1, v);
      end else begin
        bit s;
        s = 1'($urandom_range(0, 1));
        rd_chk(s, tag_of(s));
      end
      if (n % 40 == 39) chk_exports("R13 random exports");
    end
    chk_exports("R13 final exports");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule